// File: doc/BRIEF.md
# Converter Serial Output Port

This block is the serial side of a 16-bit converter's output interface. It holds the most recent conversion result in a shift register and moves it out most significant bit first on a single data line. It works in one of two roles, chosen by a strap.

In the driving role it makes its own serial clock by dividing the system clock, and it frames each word with a sync strobe. A further strap decides what starts a frame. The frame can start when a conversion begins, in which case it carries the previous result. It can instead start when a conversion completes, in which case it carries the new result.

In the following role an external serial clock shifts the word out. That clock is brought into the system clock domain through a two-stage synchronizer. Bits arriving on the serial input are passed on behind the word, so several converters can share one data line. If a read is cut short by the next result, the block raises an error pulse.

Further straps select the output code (straight binary or two's complement), the serial clock polarity and the sync polarity. Chip select and read strobe, both active low, gate the output drivers. Each tri-stateable pin has a companion enable output.

Top module: `ser_result_port`

## Requirements
- R1: In the driving role, one frame carries all 16 result bits, most significant first, one bit per serial clock period.
- R2: With `fmt_binary` high the result is sent unchanged. With it low, bit 15 is inverted (two's complement) and the other bits are unchanged. The formatted bit 15 reaches `sdout` in the cycle after `res_valid`.
- R3: In the driving role the serial clock rests at the level of `sclk_inv` outside a frame. `sdout` changes only when the clock returns to its rest level. It is therefore steady at each transition away from rest, and the receiver captures on that transition. The strobe is active for exactly 32 × DIV_HALF system cycles.
- R4: With `sync_inv` low the frame strobe is active high. With it high the strobe is active low.
- R5: With `rd_during` high a frame starts on `conv_start` and sends the word already held, while `res_valid` only loads. With it low a frame starts on `res_valid` with the new word, and `conv_start` has no effect.
- R6: In the following role with `sclk_inv` low, `sdout` advances one bit after each synchronized rising edge of `sclk_in` and holds through the next falling edge. With `sclk_inv` high the two edges trade places.
- R7: In the following role, `sdin` is captured at each sample edge once a read has begun. The bit captured at sample edge m appears on `sdout` after launch edge m+15.
- R8: In the following role, `rd_err` is high for one cycle if `res_valid` arrives after 1 to 15 launch edges of the current word. The new word replaces the old one. After 0 or 16 or more launch edges, `rd_err` stays low.
- R9: `sdout_oe` is high only while `cs_n` and `rd_n` are both low. Serial clock edges that arrive while either is high do not move the shift register.
- R10: In the driving role each serial clock level lasts DIV_HALF system cycles, and a frame has exactly 16 transitions away from the rest level.
- R11: In the following role `sclk_oe` and `sync_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| res_word | input | 16 | Conversion result |
| res_valid | input | 1 | One-cycle pulse: result complete, load it |
| conv_start | input | 1 | One-cycle pulse: a conversion has begun |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| fmt_binary | input | 1 | 1 = straight binary, 0 = two's complement |
| clk_ext | input | 1 | 0 = block drives the serial clock, 1 = external clock |
| sync_inv | input | 1 | 1 = frame strobe active low |
| sclk_inv | input | 1 | Inverts the serial clock edge roles |
| rd_during | input | 1 | Driving role: 1 = frame on conversion start, 0 = on result |
| sdin | input | 1 | Chained serial input (following role) |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sync_out | output | 1 | Frame strobe |
| sync_oe | output | 1 | Drive enable for the strobe pin |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Drive enable for the data pin |
| rd_err | output | 1 | Incomplete-read pulse |

## Verification
The hardest case to reach is the chained-data handoff in the following role. The bench must clock more than 16 external edges through the synchronizer. It must also place fresh `sdin` bits just ahead of each sample edge, so that the 15-edge offset is measured rather than assumed. The stimulus drives `sclk_in` slowly with scripted edges, six system cycles per level. It sets random `sdin` bits between each launch edge and the next sample edge. For the error pulse, the bench interrupts reads after a random number of edges from 1 to 15, and also at exactly 0 and 16 edges.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int WORD_W = 16;

    typedef enum logic {
        ROLE_DRIVE  = 1'b0,
        ROLE_FOLLOW = 1'b1
    } role_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic data;
    } edge_evt_t;

    function automatic logic [WORD_W-1:0] apply_format(
        input logic [WORD_W-1:0] w,
        input logic              straight
    );
        return straight ? w : {~w[WORD_W-1], w[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync
    import srp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_raw,
    input  logic      sdin_raw,
    output edge_evt_t evt
);
    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic              ck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q    <= '0;
            dt_q    <= '0;
            ck_last <= 1'b0;
        end else begin
            ck_q    <= {ck_q[STAGES-2:0], sclk_raw};
            dt_q    <= {dt_q[STAGES-2:0], sdin_raw};
            ck_last <= ck_q[STAGES-1];
        end
    end

    always_comb begin
        evt.rise = ck_q[STAGES-1] & ~ck_last;
        evt.fall = ~ck_q[STAGES-1] & ck_last;
        evt.data = dt_q[STAGES-1];
    end
endmodule

// File: rtl/srp_master_clkgen.sv
module srp_master_clkgen #(
    parameter int DIV_HALF = 2,
    parameter int W        = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic phase,
    output logic shift_now
);
    localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int BC_W = $clog2(W);

    logic [HC_W-1:0] hc;
    logic [BC_W-1:0] bc;
    logic            half_done;

    assign half_done = (hc == HC_W'(DIV_HALF - 1));
    assign shift_now = busy & half_done & phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            hc    <= '0;
            bc    <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            phase <= 1'b0;
            hc    <= '0;
            bc    <= '0;
        end else if (busy) begin
            if (half_done) begin
                hc    <= '0;
                phase <= ~phase;
                if (phase) begin
                    if (bc == BC_W'(W - 1)) busy <= 1'b0;
                    else                    bc   <= bc + 1'b1;
                end
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/srp_shift_reg.sv
module srp_shift_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         fill,
    input  logic         fill_bit,
    input  logic         follow,
    output logic         msb,
    output logic         rd_err
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sr;
    logic [CNT_W-1:0] cnt;
    logic             in_progress;

    assign in_progress = (cnt != '0) && (cnt < CNT_W'(W));
    assign msb         = sr[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            cnt    <= '0;
            rd_err <= 1'b0;
        end else begin
            rd_err <= load & follow & in_progress;
            if (load) begin
                sr  <= load_val;
                cnt <= '0;
            end else if (shift) begin
                sr <= {sr[W-2:0], 1'b0};
                if (cnt != CNT_W'(W)) cnt <= cnt + 1'b1;
            end else if (fill && cnt != '0) begin
                sr[0] <= fill_bit;
            end
        end
    end
endmodule

// File: rtl/ser_result_port.sv
module ser_result_port
    import srp_pkg::*;
#(
    parameter int DIV_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] res_word,
    input  logic              res_valid,
    input  logic              conv_start,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              fmt_binary,
    input  logic              clk_ext,
    input  logic              sync_inv,
    input  logic              sclk_inv,
    input  logic              rd_during,
    input  logic              sdin,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sync_out,
    output logic              sync_oe,
    output logic              sdout,
    output logic              sdout_oe,
    output logic              rd_err
);
    role_e     role;
    logic      enabled;
    edge_evt_t evt;
    logic      m_start, m_busy, m_phase, m_shift;
    logic      s_launch, s_sample;
    logic      do_shift;

    assign role    = role_e'(clk_ext);
    assign enabled = ~(cs_n | rd_n);

    srp_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .sclk_raw (sclk_in),
        .sdin_raw (sdin),
        .evt      (evt)
    );

    assign m_start = (role == ROLE_DRIVE) & (rd_during ? conv_start : res_valid);

    srp_master_clkgen #(.DIV_HALF(DIV_HALF), .W(WORD_W)) gen_i (
        .clk       (clk),
        .rst       (rst),
        .start     (m_start),
        .busy      (m_busy),
        .phase     (m_phase),
        .shift_now (m_shift)
    );

    assign s_launch = (role == ROLE_FOLLOW) & enabled & (sclk_inv ? evt.fall : evt.rise);
    assign s_sample = (role == ROLE_FOLLOW) & enabled & (sclk_inv ? evt.rise : evt.fall);
    assign do_shift = (role == ROLE_DRIVE) ? m_shift : s_launch;

    srp_shift_reg #(.W(WORD_W)) sr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (res_valid),
        .load_val (apply_format(res_word, fmt_binary)),
        .shift    (do_shift),
        .fill     (s_sample),
        .fill_bit (evt.data),
        .follow   (role == ROLE_FOLLOW),
        .msb      (sdout),
        .rd_err   (rd_err)
    );

    assign sclk_out = m_phase ^ sclk_inv;
    assign sync_out = ((role == ROLE_DRIVE) & m_busy) ^ sync_inv;
    assign sclk_oe  = enabled & (role == ROLE_DRIVE);
    assign sync_oe  = enabled & (role == ROLE_DRIVE);
    assign sdout_oe = enabled;
endmodule

// File: rtl/ser_result_port_chk.sv
module ser_result_port_chk
    import srp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic res_msb,
    input logic res_valid,
    input logic conv_start,
    input logic fmt_binary,
    input logic clk_ext,
    input logic sync_inv,
    input logic sclk_inv,
    input logic sclk_out,
    input logic sync_out,
    input logic sdout,
    input logic rd_err
);
    localparam int EC_W = $clog2(WORD_W + 2);

    logic [EC_W-1:0] ecnt;
    logic            sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt   <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_out;
            if (clk_ext || sync_out == sync_inv)
                ecnt <= '0;
            else if (sclk_out != sclk_inv && sclk_q == sclk_inv)
                ecnt <= ecnt + 1'b1;
        end
    end

    assert_fmt_load_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> sdout == ($past(res_msb) ^ ~$past(fmt_binary)));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> ($past(res_valid) && $past(clk_ext)));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> !rd_err);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_ext && !$past(clk_ext) && $stable(sclk_out) && $stable(sclk_inv)
         && !$past(res_valid) && !$past(conv_start)) |-> $stable(sdout));

    assert_rest_level_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_ext && sync_out == sync_inv) |-> sclk_out == sclk_inv);

    assert_edge_count_R10: assert property (@(posedge clk) disable iff (rst)
        ecnt <= EC_W'(WORD_W));
endmodule

bind ser_result_port ser_result_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .res_msb    (res_word[srp_pkg::WORD_W-1]),
    .res_valid  (res_valid),
    .conv_start (conv_start),
    .fmt_binary (fmt_binary),
    .clk_ext    (clk_ext),
    .sync_inv   (sync_inv),
    .sclk_inv   (sclk_inv),
    .sclk_out   (sclk_out),
    .sync_out   (sync_out),
    .sdout      (sdout),
    .rd_err     (rd_err)
);

// File: tb/ser_result_port_tb.sv
module ser_result_port_tb_top;
    localparam int DIV_HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] res_word = '0;
    logic        res_valid = 1'b0, conv_start = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1;
    logic        fmt_binary = 1'b1, clk_ext = 1'b0, sync_inv = 1'b0;
    logic        sclk_inv = 1'b0, rd_during = 1'b0, sdin = 1'b0, sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sync_out, sync_oe, sdout, sdout_oe, rd_err;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #10 clk = ~clk;

    ser_result_port #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .res_word(res_word), .res_valid(res_valid),
        .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
        .fmt_binary(fmt_binary), .clk_ext(clk_ext), .sync_inv(sync_inv),
        .sclk_inv(sclk_inv), .rd_during(rd_during), .sdin(sdin),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sync_out(sync_out), .sync_oe(sync_oe), .sdout(sdout),
        .sdout_oe(sdout_oe), .rd_err(rd_err)
    );

    function automatic logic [15:0] exp_fmt(input logic [15:0] w, input logic fb);
        return fb ? w : (w ^ 16'h8000);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic pulse_valid(input logic [15:0] w);
        res_word = w; res_valid = 1'b1;
        @(negedge clk); res_valid = 1'b0;
    endtask

    task automatic master_frame(input logic [15:0] w, input logic fb, si, ci, dm);
        logic [15:0] got;
        logic        prev;
        int          edges, run, badrun, synclen;
        bit          seen;
        clk_ext = 1'b0; fmt_binary = fb; sync_inv = si; sclk_inv = ci;
        rd_during = dm; cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sclk_out == ci, "R3 rest level", sclk_out, ci);
        chk(sync_out == si, "R4 idle strobe", sync_out, si);
        chk(sclk_oe && sync_oe && sdout_oe, "R9 drivers on", {sclk_oe, sync_oe, sdout_oe}, 3'b111);
        if (!dm) begin
            conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
            repeat (4) @(negedge clk);
            chk(sync_out == si, "R5 conv_start ignored", sync_out, si);
            pulse_valid(w);
        end else begin
            pulse_valid(w);
            repeat (6) @(negedge clk);
            chk(sync_out == si, "R5 load without frame", sync_out, si);
            conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
        end
        got = '0; prev = ci; edges = 0; run = 0; badrun = 0; synclen = 0; seen = 0;
        for (int t = 0; t < 300; t++) begin
            if (sync_out != si) begin
                seen = 1; synclen++;
                if (sclk_out != prev) begin
                    if (run != DIV_HALF) badrun++;
                    run = 1;
                    if (sclk_out != ci) begin
                        got = {got[14:0], sdout};
                        edges++;
                    end
                end else begin
                    run++;
                end
            end else if (seen) begin
                break;
            end
            prev = sclk_out;
            @(negedge clk);
        end
        chk(edges == 16, "R10 edge count", edges, 16);
        chk(badrun == 0, "R10 half period", badrun, 0);
        chk(synclen == 32 * DIV_HALF, "R3 strobe length", synclen, 32 * DIV_HALF);
        chk(got == exp_fmt(w, fb), "R1 R2 frame word", got, exp_fmt(w, fb));
        chk(sclk_out == ci, "R3 rest after frame", sclk_out, ci);
    endtask

    task automatic set_follow(input logic fb, ci);
        clk_ext = 1'b1; fmt_binary = fb; sclk_inv = ci; sclk_in = ci;
        cs_n = 1'b0; rd_n = 1'b0; sdin = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic edge_pair(input logic ci);
        sclk_in = ~ci; repeat (6) @(negedge clk);
        sclk_in = ci;  repeat (6) @(negedge clk);
    endtask

    task automatic slave_read(input logic [15:0] w, input logic fb, ci,
                              input int nb, input logic [15:0] din);
        logic [15:0] fw;
        logic        e;
        fw = exp_fmt(w, fb);
        set_follow(fb, ci);
        chk(!sclk_oe && !sync_oe && sdout_oe, "R11 follow drivers",
            {sclk_oe, sync_oe, sdout_oe}, 3'b001);
        pulse_valid(w);
        chk(sdout == fw[15], "R2 first bit", sdout, fw[15]);
        for (int n = 1; n <= nb; n++) begin
            sclk_in = ~ci; repeat (6) @(negedge clk);
            e = (n < 16) ? fw[15-n] : din[n-16];
            chk(sdout == e, (n < 16) ? "R6 launch" : "R7 chained", sdout, e);
            if (n <= 16) sdin = din[n-1];
            sclk_in = ci; repeat (6) @(negedge clk);
            chk(sdout == e, "R6 held at sample", sdout, e);
        end
    endtask

    task automatic err_probe(input logic [15:0] w2, input logic fb, input bit expect_err);
        pulse_valid(w2);
        chk(rd_err == expect_err, "R8 error pulse", rd_err, expect_err);
        @(negedge clk);
        chk(rd_err == 1'b0, "R8 pulse width", rd_err, 0);
        chk(sdout == exp_fmt(w2, fb)[15], "R8 new word", sdout, exp_fmt(w2, fb)[15]);
    endtask

    initial begin
        logic [15:0] w, w2, d;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(sdout_oe == 1'b0 && sclk_oe == 1'b0 && sync_oe == 1'b0, "R9 reset drivers off",
            {sclk_oe, sync_oe, sdout_oe}, 0);
        chk(rd_err == 1'b0, "R8 reset", rd_err, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sync_out == 1'b0, "R4 reset strobe", sync_out, 0);

        // directed driving-role frames
        master_frame(16'h8001, 1'b1, 1'b0, 1'b0, 1'b0);
        master_frame(16'h8001, 1'b0, 1'b1, 1'b1, 1'b0);
        master_frame(16'h7FFE, 1'b1, 1'b0, 1'b1, 1'b1);
        master_frame(16'h0000, 1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) begin
            w = 16'($urandom);
            master_frame(w, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // following role: full read plus chained bits, both polarities
        slave_read(16'hA5C3, 1'b1, 1'b0, 24, 16'h00B6);
        slave_read(16'h1234, 1'b0, 1'b1, 24, 16'h0049);
        for (int i = 0; i < 3; i++) begin
            w = 16'($urandom); d = 16'($urandom);
            slave_read(w, 1'($urandom), 1'($urandom), 31, d);
        end

        // incomplete read: random 1..15 edges
        for (int i = 0; i < 4; i++) begin
            w = 16'($urandom); w2 = 16'($urandom);
            slave_read(w, 1'b1, 1'($urandom), 1 + int'($urandom % 15), 16'h0);
            err_probe(w2, 1'b1, 1'b1);
        end
        // boundaries: 0 and 16 edges
        slave_read(16'h5A5A, 1'b0, 1'b0, 0, 16'h0);
        err_probe(16'hC001, 1'b0, 1'b0);
        slave_read(16'h5A5A, 1'b1, 1'b0, 16, 16'hFFFF);
        err_probe(16'h3C3C, 1'b1, 1'b0);
        slave_read(16'h5A5A, 1'b1, 1'b1, 15, 16'h0);
        err_probe(16'h0F0F, 1'b1, 1'b1);

        // disabled port ignores edges
        w = 16'h4000;
        set_follow(1'b1, 1'b0);
        pulse_valid(w);
        cs_n = 1'b1; @(negedge clk);
        chk(sdout_oe == 1'b0, "R9 cs_n off", sdout_oe, 0);
        edge_pair(1'b0); edge_pair(1'b0);
        cs_n = 1'b0; rd_n = 1'b1; @(negedge clk);
        chk(sdout_oe == 1'b0, "R9 rd_n off", sdout_oe, 0);
        edge_pair(1'b0);
        rd_n = 1'b0; @(negedge clk);
        chk(sdout == 1'b0, "R9 edges ignored", sdout, 0);
        sclk_in = 1'b1; repeat (6) @(negedge clk);
        chk(sdout == 1'b1, "R9 first enabled edge", sdout, 1);
        sclk_in = 1'b0; repeat (6) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule